// File: doc/BRIEF.md
# Register Rename Alias Table

This block renames the operands of a stream of micro-ops. A small architectural register file of eight entries is mapped onto a pool of 128 physical registers. Each cycle, one micro-op may present two source register indices and, optionally, one destination index. The block returns the physical tags that currently hold the sources. For a destination, it takes a fresh physical register from the free pool and records that register as the newest version of the architectural register. Many versions of one architectural register can therefore be in flight at the same time.

A retirement port commits micro-ops in program order. Each retirement writes the micro-op's new tag into a committed shadow map and returns the tag of the displaced older version to the free pool. A flush discards all speculative renames. It copies the committed map back into the alias table and rebuilds the free pool from it. Operand readiness and execution are handled elsewhere.

Top module: `rename_alias_table`

## Requirements
- R1: After reset, architectural register i maps to physical tag i for i = 0..7. Tags 8..127 are free, and the first allocation returns tag 8.
- R2: When a micro-op is presented, src0_tag and src1_tag combinationally give the tag most recently recorded for src0_idx and src1_idx.
- R3: Sources are looked up before the same micro-op's destination update takes effect. If a source index equals the destination index, the source tag equals prev_tag, the old version.
- R4: An accepted micro-op with dst_valid=1 receives the lowest-numbered free tag on dst_tag, and its old mapping on prev_tag. From the next cycle, lookups of dst_idx return that new tag.
- R5: in_ready is 0 when dst_valid=1 and no tag is free, and no state changes for that micro-op. A micro-op with dst_valid=0 is accepted whether or not a tag is free.
- R6: When ret_valid=1, ret_prev_tag becomes free from the next cycle and can be the next allocated tag. ret_tag becomes the committed mapping of ret_idx.
- R7: When flush=1, in_ready is 0 and the rename input is ignored. From the next cycle, the alias table equals the committed map, including any retirement in the same cycle. Exactly the 120 tags absent from that map are free.
- R8: A cycle with in_valid=0 changes neither the alias table nor the free pool, whatever the other rename inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Restore committed mapping and rebuild free pool |
| in_valid | input | 1 | A micro-op is presented for renaming |
| in_ready | output | 1 | The presented micro-op can be accepted this cycle |
| src0_idx | input | 3 | First source architectural register |
| src1_idx | input | 3 | Second source architectural register |
| dst_valid | input | 1 | The micro-op writes a destination register |
| dst_idx | input | 3 | Destination architectural register |
| src0_tag | output | 7 | Physical tag mapped to src0_idx |
| src1_tag | output | 7 | Physical tag mapped to src1_idx |
| dst_tag | output | 7 | Physical tag allocated for the destination |
| prev_tag | output | 7 | Tag previously mapped to dst_idx |
| ret_valid | input | 1 | A renamed micro-op with a destination retires |
| ret_idx | input | 3 | Architectural destination of the retiring micro-op |
| ret_tag | input | 7 | Tag the retiring micro-op allocated |
| ret_prev_tag | input | 7 | Tag the retiring micro-op displaced, to be freed |

## Verification
The bench drains the pool with 120 consecutive allocations to reach the stall. A design that miscounts free tags would accept a destination with a stale tag, or would refuse micro-ops that have no destination. It retires and allocates in the same cycle, and flushes while a retirement is in progress. A design that ignored the simultaneous retirement would restore an old committed version and leak or double-free tags. Read-and-write of the same register catches a design that forwards the new tag to its own sources. Long mixed runs against a behavioural model expose any drift in the choice of the lowest free tag.

// File: rtl/rename_pkg.sv
`timescale 1ns/1ps
package rename_pkg;
  localparam int ARCH_REGS = 8;
  localparam int PHYS_REGS = 128;
  localparam int ARCH_W    = $clog2(ARCH_REGS);
  localparam int TAG_W     = $clog2(PHYS_REGS);
  localparam int CNT_W     = $clog2(PHYS_REGS + 1);
endpackage

// File: rtl/rename_alias_map.sv
`timescale 1ns/1ps
module rename_alias_map #(
  parameter int NA = rename_pkg::ARCH_REGS,
  parameter int NP = rename_pkg::PHYS_REGS,
  localparam int AW = $clog2(NA),
  localparam int TW = $clog2(NP)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  rd0_idx,
  input  logic [AW-1:0]  rd1_idx,
  input  logic [AW-1:0]  rd2_idx,
  output logic [TW-1:0]  rd0_tag,
  output logic [TW-1:0]  rd1_tag,
  output logic [TW-1:0]  rd2_tag,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_idx,
  input  logic [TW-1:0]  wr_tag,
  input  logic           restore_en,
  input  logic [NA*TW-1:0] restore_map,
  output logic [NA*TW-1:0] map_flat
);
  logic [TW-1:0] map_q [NA];

  for (genvar i = 0; i < NA; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        map_q[i] <= TW'(i);
      else if (restore_en)
        map_q[i] <= restore_map[i*TW +: TW];
      else if (wr_en && (wr_idx == AW'(i)))
        map_q[i] <= wr_tag;
    end
    assign map_flat[i*TW +: TW] = map_q[i];
  end

  assign rd0_tag = map_q[rd0_idx];
  assign rd1_tag = map_q[rd1_idx];
  assign rd2_tag = map_q[rd2_idx];
endmodule

// File: rtl/rename_commit_map.sv
`timescale 1ns/1ps
module rename_commit_map #(
  parameter int NA = rename_pkg::ARCH_REGS,
  parameter int NP = rename_pkg::PHYS_REGS,
  localparam int AW = $clog2(NA),
  localparam int TW = $clog2(NP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ret_en,
  input  logic [AW-1:0]    ret_idx,
  input  logic [TW-1:0]    ret_tag,
  output logic [NA*TW-1:0] map_next
);
  logic [TW-1:0] cm_q [NA];

  for (genvar i = 0; i < NA; i++) begin : g_entry
    logic hit;
    assign hit = ret_en && (ret_idx == AW'(i));
    assign map_next[i*TW +: TW] = hit ? ret_tag : cm_q[i];
    always_ff @(posedge clk) begin
      if (!rst_n)
        cm_q[i] <= TW'(i);
      else if (hit)
        cm_q[i] <= ret_tag;
    end
  end
endmodule

// File: rtl/rename_free_pool.sv
`timescale 1ns/1ps
module rename_free_pool #(
  parameter int NA = rename_pkg::ARCH_REGS,
  parameter int NP = rename_pkg::PHYS_REGS,
  localparam int TW = $clog2(NP),
  localparam int CW = $clog2(NP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic             free_en,
  input  logic [TW-1:0]    free_tag,
  input  logic             rebuild_en,
  input  logic [NA*TW-1:0] rebuild_map,
  output logic [TW-1:0]    alloc_tag,
  output logic             any_free,
  output logic [CW-1:0]    free_count
);
  logic [NP-1:0] free_q;
  logic [NP-1:0] in_use;

  function automatic logic [TW-1:0] lowest_set(input logic [NP-1:0] v);
    lowest_set = '0;
    for (int t = NP - 1; t >= 0; t--)
      if (v[t]) lowest_set = TW'(t);
  endfunction

  function automatic logic [CW-1:0] ones(input logic [NP-1:0] v);
    ones = '0;
    for (int t = 0; t < NP; t++)
      ones = ones + CW'(v[t]);
  endfunction

  for (genvar t = 0; t < NP; t++) begin : g_tag
    always_comb begin
      in_use[t] = 1'b0;
      for (int i = 0; i < NA; i++)
        if (rebuild_map[i*TW +: TW] == TW'(t)) in_use[t] = 1'b1;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)
        free_q[t] <= (t >= NA);
      else if (rebuild_en)
        free_q[t] <= !in_use[t];
      else if (alloc_en && (alloc_tag == TW'(t)))
        free_q[t] <= 1'b0;
      else if (free_en && (free_tag == TW'(t)))
        free_q[t] <= 1'b1;
    end
  end

  assign alloc_tag  = lowest_set(free_q);
  assign any_free   = |free_q;
  assign free_count = ones(free_q);
endmodule

// File: rtl/rename_alias_table.sv
`timescale 1ns/1ps
module rename_alias_table #(
  parameter int NA = rename_pkg::ARCH_REGS,
  parameter int NP = rename_pkg::PHYS_REGS,
  localparam int AW = $clog2(NA),
  localparam int TW = $clog2(NP),
  localparam int CW = $clog2(NP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] src0_idx,
  input  logic [AW-1:0] src1_idx,
  input  logic          dst_valid,
  input  logic [AW-1:0] dst_idx,
  output logic [TW-1:0] src0_tag,
  output logic [TW-1:0] src1_tag,
  output logic [TW-1:0] dst_tag,
  output logic [TW-1:0] prev_tag,
  input  logic          ret_valid,
  input  logic [AW-1:0] ret_idx,
  input  logic [TW-1:0] ret_tag,
  input  logic [TW-1:0] ret_prev_tag
);
  logic             any_free;
  logic [CW-1:0]    free_count;
  logic [NA*TW-1:0] commit_next;
  logic [NA*TW-1:0] map_flat;
  logic             accept;
  logic             alloc_fire;
  logic             free_fire;

  assign in_ready   = !flush && (!dst_valid || any_free);
  assign accept     = in_valid && in_ready;
  assign alloc_fire = accept && dst_valid;
  assign free_fire  = ret_valid && !flush;

  rename_alias_map #(.NA(NA), .NP(NP)) u_map (
    .clk, .rst_n,
    .rd0_idx(src0_idx), .rd1_idx(src1_idx), .rd2_idx(dst_idx),
    .rd0_tag(src0_tag), .rd1_tag(src1_tag), .rd2_tag(prev_tag),
    .wr_en(alloc_fire), .wr_idx(dst_idx), .wr_tag(dst_tag),
    .restore_en(flush), .restore_map(commit_next),
    .map_flat(map_flat)
  );

  rename_commit_map #(.NA(NA), .NP(NP)) u_commit (
    .clk, .rst_n,
    .ret_en(ret_valid), .ret_idx(ret_idx), .ret_tag(ret_tag),
    .map_next(commit_next)
  );

  rename_free_pool #(.NA(NA), .NP(NP)) u_pool (
    .clk, .rst_n,
    .alloc_en(alloc_fire),
    .free_en(free_fire), .free_tag(ret_prev_tag),
    .rebuild_en(flush), .rebuild_map(commit_next),
    .alloc_tag(dst_tag), .any_free(any_free), .free_count(free_count)
  );
endmodule

// File: rtl/rename_alias_checker.sv
`timescale 1ns/1ps
module rename_alias_checker #(
  parameter int NA = 8,
  parameter int NP = 128,
  localparam int AW = $clog2(NA),
  localparam int TW = $clog2(NP),
  localparam int CW = $clog2(NP + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             in_valid,
  input logic             in_ready,
  input logic             dst_valid,
  input logic [AW-1:0]    src0_idx,
  input logic [AW-1:0]    dst_idx,
  input logic [TW-1:0]    src0_tag,
  input logic [TW-1:0]    dst_tag,
  input logic [TW-1:0]    prev_tag,
  input logic [TW-1:0]    ret_prev_tag,
  input logic             alloc_fire,
  input logic             free_fire,
  input logic [CW-1:0]    free_count,
  input logic [NA*TW-1:0] map_flat
);
  AST_READ_OLD_VERSION: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire && (src0_idx == dst_idx) |-> src0_tag == prev_tag); // R3

  AST_NEW_MAPPING_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> map_flat[$past(dst_idx)*TW +: TW] == $past(dst_tag)); // R4

  AST_STALL_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && dst_valid && (free_count == '0) |-> !in_ready); // R5

  AST_NO_FREE_ALLOC_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire && free_fire |-> dst_tag != ret_prev_tag); // R6

  AST_FLUSH_BLOCKS_RENAME: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_ready); // R7

  AST_FLUSH_POOL_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> free_count == CW'(NP - NA)); // R7
endmodule

bind rename_alias_table rename_alias_checker #(.NA(NA), .NP(NP)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
  .in_ready(in_ready), .dst_valid(dst_valid), .src0_idx(src0_idx),
  .dst_idx(dst_idx), .src0_tag(src0_tag), .dst_tag(dst_tag),
  .prev_tag(prev_tag), .ret_prev_tag(ret_prev_tag),
  .alloc_fire(alloc_fire), .free_fire(free_fire),
  .free_count(free_count), .map_flat(map_flat)
);

// File: tb/rename_alias_table_tb_top.sv
`timescale 1ns/1ps
module rename_alias_table_tb_top;
  localparam int NA = 8;
  localparam int NP = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0, in_valid = 1'b0, dst_valid = 1'b0, ret_valid = 1'b0;
  logic [2:0] src0_idx = '0, src1_idx = '0, dst_idx = '0, ret_idx = '0;
  logic [6:0] ret_tag = '0, ret_prev_tag = '0;
  logic in_ready;
  logic [6:0] src0_tag, src1_tag, dst_tag, prev_tag;

  always #10 clk = ~clk;

  rename_alias_table dut_i (
    .clk, .rst_n, .flush, .in_valid, .in_ready, .src0_idx, .src1_idx,
    .dst_valid, .dst_idx, .src0_tag, .src1_tag, .dst_tag, .prev_tag,
    .ret_valid, .ret_idx, .ret_tag, .ret_prev_tag
  );

  typedef struct { int arch; int tag; int prev; } op_t;
  op_t inflight[$];
  int  spec_m [NA];
  int  comm_m [NA];
  bit  pool [NP];
  int  n_chk = 0, n_fail = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int first_free();
    for (int t = 0; t < NP; t++) if (pool[t]) return t;
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NA; i++) begin spec_m[i] = i; comm_m[i] = i; end
    for (int t = 0; t < NP; t++) pool[t] = (t >= NA);
    inflight.delete();
  endtask

  task automatic step(string req, bit v, bit dv, int s0, int s1, int d, bit rv, bit fl);
    bit do_ret, exp_rdy;
    int nxt;
    op_t r;
    @(negedge clk);
    do_ret = rv && (inflight.size() > 0);
    if (do_ret) r = inflight[0];
    in_valid = v; dst_valid = dv; src0_idx = 3'(s0); src1_idx = 3'(s1);
    dst_idx = 3'(d); flush = fl; ret_valid = do_ret;
    ret_idx = do_ret ? 3'(r.arch) : '0;
    ret_tag = do_ret ? 7'(r.tag) : '0;
    ret_prev_tag = do_ret ? 7'(r.prev) : '0;
    #1;
    nxt = first_free();
    exp_rdy = !fl && (!dv || nxt >= 0);
    chk(req, "in_ready (R5)", int'(in_ready), int'(exp_rdy));
    chk(req, "src0_tag", int'(src0_tag), spec_m[s0]);
    chk(req, "src1_tag", int'(src1_tag), spec_m[s1]);
    if (v && dv && exp_rdy) begin
      chk(req, "dst_tag (R4)", int'(dst_tag), nxt);
      chk(req, "prev_tag (R4)", int'(prev_tag), spec_m[d]);
    end
    @(posedge clk);
    if (do_ret) begin
      comm_m[r.arch] = r.tag;
      void'(inflight.pop_front());
    end
    if (fl) begin
      for (int t = 0; t < NP; t++) pool[t] = 1'b1;
      for (int i = 0; i < NA; i++) begin spec_m[i] = comm_m[i]; pool[comm_m[i]] = 1'b0; end
      inflight.delete();
    end else begin
      if (v && dv && exp_rdy) begin
        op_t o;
        o.arch = d; o.tag = nxt; o.prev = spec_m[d];
        pool[nxt] = 1'b0;
        spec_m[d] = nxt;
        inflight.push_back(o);
      end
      if (do_ret) pool[r.prev] = 1'b1;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: identity map after reset
    for (int i = 0; i < NA; i++) step("R1", 1, 0, i, (i + 1) % NA, 0, 0, 0);
    // R3: read and write same register, first alloc is tag 8 (R1)
    step("R3", 1, 1, 3, 3, 3, 0, 0);
    step("R4", 1, 0, 3, 2, 0, 0, 0);
    // R8: invalid cycle with destination fields set
    step("R8", 0, 1, 3, 3, 3, 0, 0);
    step("R8", 1, 0, 3, 5, 0, 0, 0);
    // R5: drain the pool
    for (int k = 0; first_free() >= 0 && k < NP; k++)
      step("R4", 1, 1, k % NA, (k + 3) % NA, k % NA, 0, 0);
    step("R5", 1, 1, 1, 2, 4, 0, 0);
    step("R5", 1, 0, 4, 6, 0, 0, 0);
    // R6: retire frees, next alloc reuses lowest freed tag
    for (int k = 0; k < 3; k++) step("R6", 0, 0, 0, 0, 0, 1, 0);
    step("R6", 1, 1, 3, 4, 5, 1, 0);
    step("R6", 1, 1, 5, 0, 6, 0, 0);
    // R7: flush with same-cycle retire, rename ignored
    step("R7", 1, 1, 1, 2, 1, 1, 1);
    for (int i = 0; i < NA; i += 2) step("R7", 1, 0, i, i + 1, 0, 0, 0);
    step("R7", 1, 1, 0, 7, 2, 0, 0);
    // R2: mixed traffic
    for (int n = 0; n < 4000; n++) begin
      int p = int'($urandom_range(99));
      step("R2", p < 85, p < 65, int'($urandom_range(7)), int'($urandom_range(7)),
           int'($urandom_range(7)), $urandom_range(99) < 55, p == 99);
    end
    finish_run();
  end
endmodule